// File: doc/BRIEF.md
# SLIP-Framed Ethernet Frame UART Port

This block lets a low-rate endpoint exchange whole Ethernet frames with a switch over a plain asynchronous serial line. Frame boundaries on the line are marked with SLIP byte stuffing. In the receive direction, serial characters are recovered from the line, SLIP escapes are undone and delimiters are stripped. Each frame is then presented as a byte stream with a valid strobe and a last marker. In the transmit direction, a frame offered as a byte stream with a ready/valid handshake is stuffed and closed with a delimiter. It is then serialised onto the line.

The line carries no preamble, no start-of-frame byte and no inter-frame gap, and short frames are not padded. The endpoint holds off transmission through an active-low clear-to-send input. That input is only looked at between characters, so a character on the wire always completes. The rate is fixed at build time from the clock frequency and the target baud rate, 921,600 by default.

Top module: `slip_uart_port`

## Requirements
- R1: While reset is held and right after it is released, `uart_txd` is high and `rx_valid` is low.
- R2: Each line character is 8N1, least significant bit first: one low start bit, eight data bits and one high stop bit. Each bit lasts 16 × floor(CLK_HZ / (16 × BAUD)) clocks, which is 48 clocks at the defaults.
- R3: On receive, the pair 0xDB 0xDC yields data 0xC0 and the pair 0xDB 0xDD yields data 0xDB. Every other byte apart from 0xC0 and 0xDB is data as-is. A 0xC0 byte ends the frame, and `rx_last` is high on the frame's final data byte.
- R4: A 0xC0 byte that arrives with no data pending (back-to-back or leading delimiters) produces no output beat.
- R5: When 0xDB is followed by a byte other than 0xDC or 0xDD, that byte is delivered as data and the frame is flagged. When 0xDB is followed by 0xC0, the frame ends and is flagged. `rx_error` is high only together with `rx_last` of a flagged frame, and the flag does not carry into the next frame.
- R6: On transmit, data 0xC0 is sent as 0xDB 0xDC, data 0xDB is sent as 0xDB 0xDD, and other bytes are sent unchanged. Each frame is followed by exactly one 0xC0, and no delimiter is sent in front of it.
- R7: Frames of any length down to one byte are carried unpadded in both directions.
- R8: No new character starts while `uart_cts_n` has been high for more than a few clocks. A character already started finishes normally, and transmission resumes once `uart_cts_n` goes low again.
- R9: `tx_ready` is low for as long as a character is on the line.
- R10: A low pulse on `uart_rxd` that is shorter than half a bit is ignored and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_rxd | input | 1 | Serial line from the endpoint |
| uart_txd | output | 1 | Serial line to the endpoint |
| uart_cts_n | input | 1 | Endpoint ready to accept data, active low |
| rx_data | output | 8 | Received frame byte |
| rx_valid | output | 1 | rx_data holds a byte this cycle |
| rx_last | output | 1 | Byte is the last of its frame |
| rx_error | output | 1 | Frame held a bad escape (with rx_last only) |
| tx_data | input | 8 | Frame byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_last | input | 1 | Offered byte ends the frame |
| tx_ready | output | 1 | Offered byte is taken at this clock edge |

## Verification
The receive side sees data bytes equal to both reserved codes and a frame of one byte. A design that forgot to unstuff, or that emitted `rx_last` one byte late, would show the wrong byte or a misplaced last marker. Runs of bare delimiters and a bad escape in mid-frame are checked for empty frames and for an error flag that leaks into the next frame. A glitch shorter than half a bit is put on the receive line to catch a receiver that starts on any low level. On transmit, clear-to-send is raised in the middle of a character. A design that cut the character short would leave a framing error on the line, and one that ignored the gate would start a fresh start bit while blocked.

// File: rtl/slip_uart_pkg.sv
package slip_uart_pkg;
  localparam logic [7:0] SLIP_END     = 8'hC0;
  localparam logic [7:0] SLIP_ESC     = 8'hDB;
  localparam logic [7:0] SLIP_ESC_END = 8'hDC;
  localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
  typedef enum logic [1:0] {ENC_PASS, ENC_CODE, ENC_END} enc_state_t;
endpackage

// File: rtl/slip_uart_rx.sv
module slip_uart_rx
  import slip_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic [7:0] byte_o,
  output logic       byte_vld_o
);
  localparam int CW = $clog2(OVS);

  logic [1:0]    sync_q;
  logic          rxs;
  rx_state_t     st_q, st_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic [2:0]    bcnt_q, bcnt_d;
  logic [7:0]    sh_q, sh_d;
  logic          vld_q, vld_d;

  assign rxs = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    vld_d  = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: if (!rxs) begin
          st_d   = RX_START;
          tcnt_d = '0;
        end
        RX_START: begin
          tcnt_d = tcnt_q + 1'b1;
          if (tcnt_q == CW'(OVS/2 - 1)) begin
            tcnt_d = '0;
            bcnt_d = '0;
            st_d   = rxs ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          tcnt_d = tcnt_q + 1'b1;
          if (tcnt_q == CW'(OVS - 1)) begin
            tcnt_d = '0;
            sh_d   = {rxs, sh_q[7:1]};
            bcnt_d = bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) st_d = RX_STOP;
          end
        end
        RX_STOP: begin
          tcnt_d = tcnt_q + 1'b1;
          if (tcnt_q == CW'(OVS - 1)) begin
            tcnt_d = '0;
            vld_d  = rxs;
            st_d   = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
    end
  end

  assign byte_o     = sh_q;
  assign byte_vld_o = vld_q;

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/slip_decoder.sv
module slip_decoder
  import slip_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_vld,
  output logic [7:0] out_data,
  output logic       out_vld,
  output logic       out_last,
  output logic       out_err
);
  logic       esc_q, esc_d, have_q, have_d, err_q, err_d;
  logic [7:0] buf_q, buf_d, od_q, od_d;
  logic       ov_q, ov_d, ol_q, ol_d, oe_q, oe_d;
  logic       close, push, bad, err_now;
  logic [7:0] val;

  always_comb begin
    esc_d = esc_q; have_d = have_q; err_d = err_q; buf_d = buf_q;
    od_d = od_q; ov_d = 1'b0; ol_d = 1'b0; oe_d = 1'b0;
    close = 1'b0; push = 1'b0; bad = 1'b0; val = in_byte;
    if (in_vld) begin
      if (esc_q) begin
        esc_d = 1'b0;
        if (in_byte == SLIP_END) begin
          close = 1'b1;
          bad   = 1'b1;
        end else begin
          push = 1'b1;
          if (in_byte == SLIP_ESC_END)      val = SLIP_END;
          else if (in_byte == SLIP_ESC_ESC) val = SLIP_ESC;
          else                              bad = 1'b1;
        end
      end else if (in_byte == SLIP_END) close = 1'b1;
      else if (in_byte == SLIP_ESC)     esc_d = 1'b1;
      else                              push  = 1'b1;
    end
    err_now = err_q | bad;
    if (push) begin
      if (have_q) begin
        ov_d = 1'b1;
        od_d = buf_q;
      end
      buf_d  = val;
      have_d = 1'b1;
      err_d  = err_now;
    end
    if (close) begin
      if (have_q) begin
        ov_d = 1'b1;
        od_d = buf_q;
        ol_d = 1'b1;
        oe_d = err_now;
      end
      have_d = 1'b0;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esc_q <= 1'b0; have_q <= 1'b0; err_q <= 1'b0; buf_q <= '0;
      od_q <= '0; ov_q <= 1'b0; ol_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      esc_q <= esc_d; have_q <= have_d; err_q <= err_d; buf_q <= buf_d;
      od_q <= od_d; ov_q <= ov_d; ol_q <= ol_d; oe_q <= oe_d;
    end
  end

  assign out_data = od_q;
  assign out_vld  = ov_q;
  assign out_last = ol_q;
  assign out_err  = oe_q;

  p_err_with_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && oe_q) |-> ol_q);
  p_beat_needs_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> $past(in_vld));
endmodule

// File: rtl/slip_encoder.sv
module slip_encoder
  import slip_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic [7:0] m_data,
  output logic       m_valid,
  input  logic       m_ready
);
  enc_state_t st_q, st_d;
  logic [7:0] code_q, code_d;
  logic       last_q, last_d;
  logic       special;

  assign special = (s_data == SLIP_END) || (s_data == SLIP_ESC);

  always_comb begin
    st_d = st_q; code_d = code_q; last_d = last_q;
    m_valid = 1'b0; m_data = s_data; s_ready = 1'b0;
    case (st_q)
      ENC_PASS: begin
        m_valid = s_valid;
        m_data  = special ? SLIP_ESC : s_data;
        s_ready = m_ready;
        if (s_valid && m_ready) begin
          if (special) begin
            st_d   = ENC_CODE;
            code_d = (s_data == SLIP_END) ? SLIP_ESC_END : SLIP_ESC_ESC;
            last_d = s_last;
          end else if (s_last) begin
            st_d = ENC_END;
          end
        end
      end
      ENC_CODE: begin
        m_valid = 1'b1;
        m_data  = code_q;
        if (m_ready) st_d = last_q ? ENC_END : ENC_PASS;
      end
      ENC_END: begin
        m_valid = 1'b1;
        m_data  = SLIP_END;
        if (m_ready) st_d = ENC_PASS;
      end
      default: st_d = ENC_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ENC_PASS; code_q <= SLIP_ESC_END; last_q <= 1'b0;
    end else begin
      st_q <= st_d; code_q <= code_d; last_q <= last_d;
    end
  end

  p_no_raw_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENC_PASS && m_valid) |-> (m_data != SLIP_END));
  p_code_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENC_CODE) |-> (code_q == SLIP_ESC_END || code_q == SLIP_ESC_ESC));
endmodule

// File: rtl/slip_uart_tx.sv
module slip_uart_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cts_n,
  input  logic [7:0] in_data,
  input  logic       in_vld,
  output logic       in_rdy,
  output logic       txd
);
  localparam int CW = $clog2(OVS);

  logic [1:0]    cts_q;
  logic          busy_q, busy_d;
  logic [9:0]    sh_q, sh_d;
  logic [3:0]    bits_q, bits_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic          txd_q, txd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_q <= 2'b11;
    else        cts_q <= {cts_q[0], cts_n};
  end

  assign in_rdy = !busy_q && tick && !cts_q[1];

  always_comb begin
    busy_d = busy_q; sh_d = sh_q; bits_d = bits_q; tcnt_d = tcnt_q;
    if (in_vld && in_rdy) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, in_data, 1'b0};
      bits_d = 4'd9;
      tcnt_d = '0;
    end else if (busy_q && tick) begin
      tcnt_d = tcnt_q + 1'b1;
      if (tcnt_q == CW'(OVS - 1)) begin
        tcnt_d = '0;
        sh_d   = {1'b1, sh_q[9:1]};
        if (bits_q == 4'd0) busy_d = 1'b0;
        else                bits_d = bits_q - 1'b1;
      end
    end
    txd_d = busy_d ? sh_d[0] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sh_q <= '1; bits_q <= '0; tcnt_q <= '0; txd_q <= 1'b1;
    end else begin
      busy_q <= busy_d; sh_q <= sh_d; bits_q <= bits_d; tcnt_q <= tcnt_d; txd_q <= txd_d;
    end
  end

  assign txd = txd_q;

  p_start_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(!cts_q[1]));
  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_q);
endmodule

// File: rtl/slip_uart_port.sv
module slip_uart_port
  import slip_uart_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 921_600,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uart_rxd,
  output logic       uart_txd,
  input  logic       uart_cts_n,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_last,
  output logic       rx_error,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  input  logic       tx_last,
  output logic       tx_ready
);
  localparam int RAW_DIV  = CLK_HZ / (BAUD * OVS);
  localparam int TICK_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int DIV_W    = $clog2(TICK_DIV + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             tick_q, tick_d;
  logic [7:0]       rbyte, sbyte;
  logic             rbyte_vld, svld, srdy;

  always_comb begin
    tick_d = (div_q == DIV_W'(TICK_DIV - 1));
    div_d  = tick_d ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      tick_q <= tick_d;
    end
  end

  slip_uart_rx #(.OVS(OVS)) i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_q), .rxd(uart_rxd),
    .byte_o(rbyte), .byte_vld_o(rbyte_vld)
  );

  slip_decoder i_dec (
    .clk(clk), .rst_n(rst_n), .in_byte(rbyte), .in_vld(rbyte_vld),
    .out_data(rx_data), .out_vld(rx_valid), .out_last(rx_last), .out_err(rx_error)
  );

  slip_encoder i_enc (
    .clk(clk), .rst_n(rst_n),
    .s_data(tx_data), .s_valid(tx_valid), .s_last(tx_last), .s_ready(tx_ready),
    .m_data(sbyte), .m_valid(svld), .m_ready(srdy)
  );

  slip_uart_tx #(.OVS(OVS)) i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_q), .cts_n(uart_cts_n),
    .in_data(sbyte), .in_vld(svld), .in_rdy(srdy), .txd(uart_txd)
  );
endmodule

// File: tb/test_slip_uart_port.sv
module test_slip_uart_port;
  localparam int CLK_HZ   = 50_000_000;
  localparam int BAUD     = 921_600;
  localparam int BIT_CLKS = 16 * (CLK_HZ / (BAUD * 16));

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n, uart_rxd, uart_txd, uart_cts_n;
  logic [7:0] rx_data, tx_data;
  logic rx_valid, rx_last, rx_error, tx_valid, tx_last, tx_ready;

  int errors = 0;
  int checks = 0;
  int r9_viol = 0;
  bit mon_en = 1'b0;
  bit mon_busy = 1'b0;
  bit cts_block = 1'b0;
  logic [9:0] rx_q[$];
  logic [7:0] tx_q[$];

  always #10 clk = ~clk;

  slip_uart_port i_slip_uart_port (
    .clk(clk), .rst_n(rst_n), .uart_rxd(uart_rxd), .uart_txd(uart_txd),
    .uart_cts_n(uart_cts_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_last(rx_last), .rx_error(rx_error), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bq_t slip_enc(bq_t d);
    bq_t r;
    foreach (d[i]) begin
      if (d[i] == 8'hC0) begin r.push_back(8'hDB); r.push_back(8'hDC); end
      else if (d[i] == 8'hDB) begin r.push_back(8'hDB); r.push_back(8'hDD); end
      else r.push_back(d[i]);
    end
    r.push_back(8'hC0);
    return r;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  // Receive reference: every output beat is compared against the model queue
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rx_q.size() == 0) begin
        chk(1'b0, "R4 unexpected rx beat", {rx_error, rx_last, rx_data}, 0);
      end else begin
        logic [9:0] e;
        e = rx_q.pop_front();
        chk({rx_error, rx_last, rx_data} == e, "R3 R5 R7 rx beat {err,last,data}",
            {rx_error, rx_last, rx_data}, e);
      end
    end
    if (mon_busy && tx_ready) r9_viol++;
  end

  // Line decoder on uart_txd
  initial begin : txmon
    forever begin
      @(negedge clk);
      if (mon_en && uart_txd == 1'b0) begin
        logic [7:0] b;
        mon_busy = 1'b1;
        if (cts_block) chk(1'b0, "R8 start bit while blocked", 1, 0);
        repeat (BIT_CLKS/2 - 1) @(negedge clk);
        chk(uart_txd == 1'b0, "R2 start bit", uart_txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CLKS) @(negedge clk);
          b[i] = uart_txd;
        end
        repeat (BIT_CLKS) @(negedge clk);
        chk(uart_txd == 1'b1, "R2 R8 stop bit", uart_txd, 1);
        if (tx_q.size() == 0) chk(1'b0, "R6 unexpected tx byte", b, 0);
        else begin
          logic [7:0] e;
          e = tx_q.pop_front();
          chk(b == e, "R6 R7 tx line byte", b, e);
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic rx_byte(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      uart_rxd = f[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic rx_raw(input bq_t d);
    foreach (d[i]) rx_byte(d[i]);
  endtask

  task automatic rx_clean(input bq_t d);
    foreach (d[i]) rx_q.push_back({1'b0, (i == d.size() - 1), d[i]});
    rx_raw(slip_enc(d));
  endtask

  task automatic tx_frame(input bq_t d);
    bq_t e;
    e = slip_enc(d);
    foreach (e[i]) tx_q.push_back(e[i]);
    foreach (d[i]) begin
      tx_valid = 1'b1;
      tx_data  = d[i];
      tx_last  = (i == d.size() - 1);
      forever begin
        #1;
        if (tx_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    tx_valid = 1'b0;
    tx_last  = 1'b0;
  endtask

  task automatic wait_drained();
    int n = 0;
    while ((rx_q.size() != 0 || tx_q.size() != 0 || mon_busy) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  initial begin : main
    bq_t d;
    rst_n = 1'b0; uart_rxd = 1'b1; uart_cts_n = 1'b0;
    tx_valid = 1'b0; tx_last = 1'b0; tx_data = '0;
    repeat (5) @(negedge clk);
    chk(uart_txd == 1'b1, "R1 txd idle in reset", uart_txd, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(uart_txd == 1'b1, "R1 txd idle after reset", uart_txd, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);
    mon_en = 1'b1;

    // R3: both reserved codes as data
    d = '{8'h11, 8'hC0, 8'hDB, 8'h7E};
    rx_clean(d);
    // R4: bare delimiters, then a normal frame
    d = '{8'hC0, 8'hC0, 8'hC0};
    rx_raw(d);
    d = '{8'h55, 8'hAA};
    rx_clean(d);
    // R5: bad escape mid-frame, flag on last beat only
    rx_q.push_back({1'b0, 1'b0, 8'h31});
    rx_q.push_back({1'b0, 1'b0, 8'h41});
    rx_q.push_back({1'b1, 1'b1, 8'h32});
    d = '{8'h31, 8'hDB, 8'h41, 8'h32, 8'hC0};
    rx_raw(d);
    // R5: escape then delimiter closes a flagged frame
    rx_q.push_back({1'b1, 1'b1, 8'h66});
    d = '{8'h66, 8'hDB, 8'hC0};
    rx_raw(d);
    // R7: single-byte frame, flag does not carry over (R5)
    d = '{8'h01};
    rx_clean(d);
    // R10: short glitch is ignored
    uart_rxd = 1'b0;
    repeat (10) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (4 * BIT_CLKS) @(negedge clk);
    d = '{8'h5A};
    rx_clean(d);
    wait_drained();
    chk(rx_q.size() == 0, "R3 R10 rx frames all delivered", rx_q.size(), 0);

    // R6: transmit stuffing and closing delimiter
    d = '{8'h41, 8'hC0, 8'hDB, 8'h42};
    tx_frame(d);
    // R7: one-byte frames
    d = '{8'hC0};
    tx_frame(d);
    d = '{8'h00};
    tx_frame(d);
    wait_drained();

    // R8: block mid-character, then release
    fork
      begin
        d = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        tx_frame(d);
      end
      begin
        while (!mon_busy) @(negedge clk);
        repeat (BIT_CLKS * 3) @(negedge clk);
        uart_cts_n = 1'b1;
        repeat (5) @(negedge clk);
        cts_block = 1'b1;
        repeat (3000) @(negedge clk);
        chk(mon_busy == 1'b0, "R8 line idle while blocked", mon_busy, 0);
        cts_block = 1'b0;
        uart_cts_n = 1'b0;
      end
    join
    wait_drained();
    chk(tx_q.size() == 0, "R6 R8 all tx bytes seen", tx_q.size(), 0);
    chk(r9_viol == 0, "R9 tx_ready low during character", r9_viol, 0);
    finish_run();
  end
endmodule